// File: doc/BRIEF.md
# Flash-Clearable Separate-Port RAM

This block is a synchronous single-clock memory of 1024 words by 4 bits. Write data and read data use two separate buses. The read path is registered, and it carries a drive-enable flag that stands in for a three-state output. Four active-low controls pick the operation on each rising clock edge: select, output enable, write enable and clear.

A clear zeroes the whole array at once and does not step through the words. A per-word valid bit vector is wiped on the edge that accepts the clear. Any word whose valid bit is low reads back as zero, and a write sets that word's bit again. A busy flag marks the second cycle of each clear. A read issued in that cycle already returns zero.

Top module: `fcr_ram`

## Requirements
- R1: The array holds 1024 distinct 4-bit words, addressed 0 to 1023. Each word keeps the last value written to it until a clear or a system reset.
- R2: While `sel_n` is 1, the next cycle shows `rd_en` = 0 and the memory is left unchanged, whatever the other controls are.
- R3: With `sel_n`=0, `clr_n`=1, `wen_n`=1 and `oen_n`=0 at an edge, that edge loads the addressed word into `rd_data` and sets `rd_en` = 1. Both appear in the cycle after the edge.
- R4: With `sel_n`=0, `clr_n`=1 and `wen_n`=0, `wr_data` is stored at `addr` and `rd_en` is 0 in the next cycle. `oen_n` has no effect.
- R5: With `sel_n`=0, `clr_n`=1, `wen_n`=1 and `oen_n`=1, the output is not driven (`rd_en` = 0) and no word changes.
- R6: With `sel_n`=0, `clr_n`=0 and `wen_n`=1, every word becomes zero and `rd_en` is 0 in the next cycle.
- R7: A clear takes priority over a read: `oen_n`=0 during a clear still gives `rd_en` = 0.
- R8: `clr_n`=0 together with `wen_n`=0 is neither a clear nor a write. No word changes, `busy` stays 0 and `rd_en` is 0.
- R9: `busy` is 1 in exactly the cycles that follow an edge on which a clear was accepted. A clear held for N edges gives N busy cycles in a row.
- R10: A read issued in the busy cycle right after a clear returns 0. A word written after a clear reads back the written value.
- R11: Whenever `rd_en` is 0, `rd_data` is 0.
- R12: A synchronous reset (`rst_n`=0 at an edge) gives `rd_en`=0, `rd_data`=0 and `busy`=0. After the reset every word reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low system reset |
| sel_n | input | 1 | Active-low select |
| clr_n | input | 1 | Active-low bulk clear request |
| oen_n | input | 1 | Active-low output enable for reads |
| wen_n | input | 1 | Active-low write enable |
| addr | input | 10 | Word address |
| wr_data | input | 4 | Data to store on a write |
| rd_data | output | 4 | Registered read data, 0 when not driving |
| rd_en | output | 1 | Output drive flag, one cycle after the decoded mode |
| busy | output | 1 | High in the second cycle of a clear |

## Verification
The bench targets the clear path. It reads a written word in the busy cycle itself, where a design that fails to wipe the valid bits at once returns stale data. It then sweeps all 1024 addresses, where a partial or stepped wipe leaves a non-zero word. It holds the clear with output enable low and then with write enable low: a design with the wrong priority drives the output during a clear, and a design that treats the second case as a clear or a write loses or overwrites data. It holds a clear over three edges to catch a busy flag that pulses once instead of following each accepted clear. It writes after a clear to catch a design that never sets the valid bit again.

// File: rtl/fcr_pkg.sv
// Package: shared mode type and truth-table decode for the flash-clearable RAM.
// Assumes all controls are active low and sampled on the same clock edge.
package fcr_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE  = 3'd0,   // not selected, or invalid clear+write combination
        MODE_OFF   = 3'd1,   // selected, output disabled, no access
        MODE_READ  = 3'd2,
        MODE_WRITE = 3'd3,
        MODE_CLEAR = 3'd4
    } fcr_mode_e;

    // Map the four controls to a mode; clear wins over read, and clear needs wen_n high.
    function automatic fcr_mode_e fcr_mode_of(input logic sel_n, input logic clr_n,
                                              input logic oen_n, input logic wen_n);
        fcr_mode_e m;
        if (sel_n)
            m = MODE_IDLE;
        else if (!clr_n)
            m = wen_n ? MODE_CLEAR : MODE_IDLE;
        else if (!wen_n)
            m = MODE_WRITE;
        else if (!oen_n)
            m = MODE_READ;
        else
            m = MODE_OFF;
        return m;
    endfunction

endpackage

// File: rtl/fcr_decode.sv
// Module: fcr_decode
// Turns the active-low controls into one strobe per operation.
// Assumes: strobes are suppressed while the synchronous reset is asserted.
module fcr_decode
    import fcr_pkg::*;
(
    input  logic      rst_n,
    input  logic      sel_n,
    input  logic      clr_n,
    input  logic      oen_n,
    input  logic      wen_n,
    output fcr_mode_e mode,
    output logic      rd_go,
    output logic      wr_go,
    output logic      clr_go
);

    // Decode the mode and gate the strobes with reset.
    always_comb begin
        mode   = fcr_mode_of(sel_n, clr_n, oen_n, wen_n);
        rd_go  = rst_n && (mode == MODE_READ);
        wr_go  = rst_n && (mode == MODE_WRITE);
        clr_go = rst_n && (mode == MODE_CLEAR);
    end

endmodule

// File: rtl/fcr_valid.sv
// Module: fcr_valid
// Keeps one valid bit per word. A clear wipes all bits in one edge and a write sets one.
// Also generates the busy flag for the second cycle of a clear.
// Assumes: clr_go and wr_go are never high together.
module fcr_valid #(
    parameter int ADDR_W = 10,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_go,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] addr,
    output logic              word_valid,
    output logic              busy
);

    logic [DEPTH-1:0] valid_q;
    logic             busy_q;

    // Wipe or mark valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_go)
            valid_q <= '0;
        else if (wr_go)
            valid_q[addr] <= 1'b1;
    end

    // Busy follows an accepted clear by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else
            busy_q <= clr_go;
    end

    assign word_valid = valid_q[addr];
    assign busy       = busy_q;

    // R6
    wipe_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_go |=> (valid_q == '0));
    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_go |=> busy);
    // R9
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_go |=> !busy);
    // R10
    mark_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> valid_q[$past(addr)]);

endmodule

// File: rtl/fcr_array.sv
// Module: fcr_array
// Data storage with one write port and an asynchronous read of the same address.
// Assumes: contents are not reset; validity is tracked outside.
module fcr_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store write data at the addressed word.
    always_ff @(posedge clk) begin
        if (wr_go)
            mem[addr] <= wr_data;
    end

    assign word = mem[addr];

    // R4
    store_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (mem[$past(addr)] == $past(wr_data)));

endmodule

// File: rtl/fcr_rdport.sv
// Module: fcr_rdport
// Registered read output with a drive flag. Data is forced to zero when not driving
// or when the word is not valid.
// Assumes: word and word_valid refer to the same address in the read cycle.
module fcr_rdport #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_en
);

    // Capture the read result and drive flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_en   <= 1'b0;
        end else begin
            rd_data <= (rd_go && word_valid) ? word : '0;
            rd_en   <= rd_go;
        end
    end

    // R11
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
    // R10
    stale_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !word_valid) |=> (rd_data == '0));

endmodule

// File: rtl/fcr_ram.sv
// Module: fcr_ram (top)
// Flash-clearable 1K x 4 RAM with separate data ports, registered read data,
// a drive flag and a busy flag during clear.
// Assumes: a single clock and synchronous active-low reset; all controls active low.
module fcr_ram
    import fcr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              clr_n,
    input  logic              oen_n,
    input  logic              wen_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_en,
    output logic              busy
);

    fcr_mode_e         mode;
    logic              rd_go, wr_go, clr_go;
    logic              word_valid;
    logic [DATA_W-1:0] word;

    fcr_decode u_decode (
        .rst_n (rst_n), .sel_n (sel_n), .clr_n (clr_n), .oen_n (oen_n), .wen_n (wen_n),
        .mode (mode), .rd_go (rd_go), .wr_go (wr_go), .clr_go (clr_go)
    );

    fcr_valid #(.ADDR_W(ADDR_W)) u_valid (
        .clk (clk), .rst_n (rst_n), .clr_go (clr_go), .wr_go (wr_go),
        .addr (addr), .word_valid (word_valid), .busy (busy)
    );

    fcr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk (clk), .rst_n (rst_n), .wr_go (wr_go), .addr (addr),
        .wr_data (wr_data), .word (word)
    );

    fcr_rdport #(.DATA_W(DATA_W)) u_rdport (
        .clk (clk), .rst_n (rst_n), .rd_go (rd_go), .word_valid (word_valid),
        .word (word), .rd_data (rd_data), .rd_en (rd_en)
    );

    // R2
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !rd_en);
    // R3
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && clr_n && wen_n && !oen_n) |=> rd_en);
    // R7
    clear_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !clr_n && wen_n) |=> (!rd_en && busy));
    // R8
    bad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !clr_n && !wen_n) |=> (!rd_en && !busy));
    // R5
    out_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && clr_n && wen_n && oen_n) |=> !rd_en);

endmodule

// File: tb/fcr_ram_test.sv
// Directed bench for fcr_ram: one task per scenario, with a reference array kept in the bench.
module fcr_ram_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1, clr_n = 1'b1, oen_n = 1'b1, wen_n = 1'b1;
    logic [9:0] addr = '0;
    logic [3:0] wr_data = '0;
    logic [3:0] rd_data;
    logic       rd_en, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [3:0] model [1024];

    fcr_ram uut (
        .clk (clk), .rst_n (rst_n), .sel_n (sel_n), .clr_n (clr_n), .oen_n (oen_n),
        .wen_n (wen_n), .addr (addr), .wr_data (wr_data),
        .rd_data (rd_data), .rd_en (rd_en), .busy (busy)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply controls at a falling edge, pass one rising edge, return at the next falling edge.
    task automatic step(input logic s, input logic c, input logic o, input logic w,
                        input logic [9:0] a, input logic [3:0] d);
        sel_n = s; clr_n = c; oen_n = o; wen_n = w; addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b1, 1'b1, 1'b1, 1'b1, 10'd0, 4'd0);
    endtask

    task automatic wr(input logic [9:0] a, input logic [3:0] d, input logic o);
        step(1'b0, 1'b1, o, 1'b0, a, d);
        model[a] = d;
        chk("R4 write rd_en", rd_en, 0);
    endtask

    task automatic rd(input logic [9:0] a, input string req);
        step(1'b0, 1'b1, 1'b0, 1'b1, a, 4'd0);
        chk({req, " rd_data"}, rd_data, model[a]);
        chk({req, " rd_en"}, rd_en, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(); idle();
        chk("R12 rd_en", rd_en, 0);
        chk("R12 rd_data", rd_data, 0);
        chk("R12 busy", busy, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 1024; i++) model[i] = 4'd0;
        rd(10'd5, "R12 after reset");
        rd(10'd1023, "R12 after reset");
    endtask

    task automatic t_write_read();
        wr(10'd0, 4'hA, 1'b0);
        wr(10'd1023, 4'h5, 1'b1);
        wr(10'h155, 4'hF, 1'b0);
        wr(10'h2AA, 4'h3, 1'b1);
        rd(10'd0, "R1 R3");
        rd(10'd1023, "R1 R3");
        rd(10'h155, "R1 R3");
        rd(10'h2AA, "R1 R3");
        wr(10'h155, 4'h6, 1'b0);
        rd(10'h155, "R1 overwrite");
    endtask

    task automatic t_deselect();
        step(1'b1, 1'b0, 1'b0, 1'b1, 10'd0, 4'h0);
        chk("R2 clear deselected rd_en", rd_en, 0);
        chk("R2 clear deselected busy", busy, 0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 10'd0, 4'h9);
        chk("R2 write deselected rd_en", rd_en, 0);
        chk("R11 rd_data quiet", rd_data, 0);
        rd(10'd0, "R2 unchanged");
    endtask

    task automatic t_outoff();
        step(1'b0, 1'b1, 1'b1, 1'b1, 10'd1023, 4'h0);
        chk("R5 rd_en", rd_en, 0);
        chk("R11 rd_data", rd_data, 0);
        rd(10'd1023, "R5 unchanged");
    endtask

    task automatic t_bad_clear();
        step(1'b0, 1'b0, 1'b0, 1'b0, 10'h2AA, 4'hC);
        chk("R8 rd_en", rd_en, 0);
        chk("R8 busy", busy, 0);
        rd(10'h2AA, "R8 no write");
        rd(10'd0, "R8 no clear");
    endtask

    task automatic t_clear();
        wr(10'd7, 4'h7, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 10'd7, 4'h0);
        chk("R7 rd_en during clear", rd_en, 0);
        chk("R9 busy after clear", busy, 1);
        for (int i = 0; i < 1024; i++) model[i] = 4'd0;
        rd(10'd7, "R10 read in busy cycle");
        chk("R9 busy dropped", busy, 0);
        for (int i = 0; i < 1024; i++) begin
            step(1'b0, 1'b1, 1'b0, 1'b1, i[9:0], 4'd0);
            if (i == 0 || i == 1023 || rd_data !== 4'd0)
                chk("R6 word zero", rd_data, 0);
        end
        wr(10'd9, 4'hB, 1'b1);
        rd(10'd9, "R10 write after clear");
        rd(10'd8, "R10 neighbour still zero");
    endtask

    task automatic t_long_clear();
        wr(10'd3, 4'h4, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b1, 10'd0, 4'h0);
        chk("R9 busy hold 1", busy, 1);
        step(1'b0, 1'b0, 1'b1, 1'b1, 10'd0, 4'h0);
        chk("R9 busy hold 2", busy, 1);
        step(1'b0, 1'b0, 1'b0, 1'b1, 10'd0, 4'h0);
        chk("R9 busy hold 3", busy, 1);
        chk("R6 rd_en during clear", rd_en, 0);
        model[3] = 4'd0;
        idle();
        chk("R9 busy end", busy, 0);
        rd(10'd3, "R6 long clear");
    endtask

    task automatic t_reset_after_data();
        wr(10'd100, 4'hE, 1'b0);
        rd(10'd100, "R3 before reset");
        t_reset();
        rd(10'd100, "R12 data gone");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_write_read();
        t_deselect();
        t_outoff();
        t_bad_clear();
        t_clear();
        t_long_clear();
        t_reset_after_data();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule